// File: doc/BRIEF.md
# Chained Double-Buffered Burst DMA Channel

This block is a single DMA channel that streams audio samples between system memory and a peripheral FIFO in fixed bursts of 32-bit words. Software sets it up through three word registers: a control/status word at offset 0x0, a pending-buffer address at 0x4 and a pending-buffer byte count at 0x8. The pending pair sits in front of a current address/count pair that drives the bursts. When the current buffer runs out, the queued buffer takes its place without software having to step in, so playback or capture runs without gaps. Software refills the queue on each terminal-count interrupt.

The memory side issues a request with a valid/ready handshake. The request carries an address, a write flag and a beat count. Data beats then follow on a read channel or a write channel. The peripheral side is a 32-bit valid/ready stream, and the direction bit picks which way it flows. A soft reset bit aborts the channel. The channel only reports that it is quiet once any outstanding request has been accepted and the rest of an accepted burst has been drained.

Control/status bit layout (bit: meaning): 0 soft reset (RW), 1 terminal count TC (write 1 to clear), 2 request pending (RO), 3 draining (RO), 4 chain enable (RW), 5 to-memory direction (RW), 6 DMA enable (RW), 7 counter enable (RW), 8 interrupt enable (RW), 9 interrupt pending (RO), 10 error (RO), 12:11 burst-size code (RW, stored only; bursts are always 16 words).

Top module: `chain_dma_chan`

## Requirements
- R1: After the synchronous reset, the control/status word reads 0x0, irq is low and no memory request is raised.
- R2: A count write followed by an address write loads the current address and count directly when no current buffer exists. Reads of 0x4/0x8 return the current address/count while DMA enable (bit 6) is clear, and the pending registers while it is set.
- R3: An address write while a current buffer exists queues the pending pair. When the current count reaches zero with chain enable (bit 4) set, the queued pair becomes current and bursts continue from the queued address.
- R4: Every request carries a 64-byte-aligned address and a beat count of 16. Successive bursts of one buffer advance by 64 bytes. The low 6 bits of a written byte count are ignored.
- R5: When the count reaches zero, TC (bit 1) is set. With no queued buffer, or with chain enable clear, the channel raises no further requests and TC stays set.
- R6: A control/status write with bit 1 set clears TC, while the other writable bits take the written values. A write with bit 1 clear leaves TC unchanged.
- R7: Interrupt pending (bit 9) equals TC while interrupt enable (bit 8) is set. The irq output is high when interrupt pending or error (bit 10) is set.
- R8: Clearing DMA enable lets a burst already in flight finish, then starts no new burst and keeps the address and count. Setting it again resumes from the held address.
- R9: Writing bit 0 set clears TC, error, the current buffer and the queued buffer, and blocks new requests. Bit 2 reads 1 while a request is still unaccepted. Bit 3 reads 1 while the remaining beats of an accepted burst are consumed: read data is discarded and zeros are written.
- R10: An error response during a burst's data phase abandons the burst. So does writing an address whose low 6 bits are not zero; that address is not loaded. Either case sets error (bit 10), and no further requests are raised until a soft reset write.
- R11: With bit 5 clear, memory read data goes to the peripheral transmit stream. With bit 5 set, requests carry the write flag and peripheral receive words are written to memory in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on reg_rdata one cycle later |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| mem_req_valid | output | 1 | Burst request valid |
| mem_req_ready | input | 1 | Burst request accepted |
| mem_req_addr | output | ADDR_W | Burst start byte address |
| mem_req_write | output | 1 | Burst writes memory |
| mem_req_len | output | LEN_W | Beats in the burst |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | DATA_W | Read beat data |
| mem_rready | output | 1 | Read beat accepted |
| mem_wvalid | output | 1 | Write beat valid |
| mem_wdata | output | DATA_W | Write beat data |
| mem_wready | input | 1 | Write beat accepted |
| mem_err | input | 1 | Error response during a burst |
| per_tx_valid | output | 1 | Word to peripheral valid |
| per_tx_ready | input | 1 | Peripheral takes the word |
| per_tx_data | output | DATA_W | Word to peripheral |
| per_rx_valid | input | 1 | Word from peripheral valid |
| per_rx_ready | output | 1 | Channel takes the word |
| per_rx_data | input | DATA_W | Word from peripheral |

## Verification
Chaining is tried with a table of buffer pairs. The pairs differ in length, in the placement of the queued address, and in a count whose low bits must be dropped. The logged burst address sequence shows whether the reload happened at exactly the right burst, and whether truncation shortened the queued buffer. Separate patterns cover a buffer with nothing queued, a halt in the middle of a buffer, and capture direction. Each one shows something the others cannot: stopping with TC held, address and count held across a halt, and the write flag with receive ordering. Stalled request and stalled data patterns tell the pending-request phase of the reset handshake apart from the drain phase.

// File: rtl/chain_dma_pkg.sv
`timescale 1ns/1ps
package chain_dma_pkg;
  // Register offsets
  localparam logic [3:0] OFF_CSR  = 4'h0;
  localparam logic [3:0] OFF_ADDR = 4'h4;
  localparam logic [3:0] OFF_CNT  = 4'h8;

  // Control/status bit positions
  localparam int CSR_RST   = 0;
  localparam int CSR_TC    = 1;
  localparam int CSR_CPEND = 2;
  localparam int CSR_DRAIN = 3;
  localparam int CSR_CHAIN = 4;
  localparam int CSR_TOMEM = 5;
  localparam int CSR_EN    = 6;
  localparam int CSR_CNTEN = 7;
  localparam int CSR_IEN   = 8;
  localparam int CSR_IPEND = 9;
  localparam int CSR_ERR   = 10;
  localparam int CSR_BSZ   = 11;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_REQ   = 2'd1,
    ENG_DATA  = 2'd2,
    ENG_DRAIN = 2'd3
  } eng_state_t;
endpackage

// File: rtl/chain_dma_regs.sv
`timescale 1ns/1ps
module chain_dma_regs
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 24,
  parameter int BURST_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  input  logic              burst_done,
  input  logic              burst_err,
  input  logic              cyc_pend,
  input  logic              draining,
  output logic              go,
  output logic              to_mem_o,
  output logic              abort_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] cur_addr_o
);
  localparam int BLK_LSB = $clog2(BURST_BYTES);

  // control bits
  logic       rst_bit, chain_en, to_mem, dma_en, cnt_en, int_en;
  logic [1:0] bsz;
  // status
  logic       tc_q, err_q;
  // buffer pairs
  logic              cur_valid, armed;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;
  logic [CNT_W-1:0]  cur_cnt, nxt_cnt;

  logic csr_wr, adr_wr, cnt_wr, term, misaligned;
  logic [31:0] csr_view;

  assign csr_wr     = reg_wr && (reg_addr == OFF_CSR);
  assign adr_wr     = reg_wr && (reg_addr == OFF_ADDR);
  assign cnt_wr     = reg_wr && (reg_addr == OFF_CNT);
  assign misaligned = |reg_wdata[BLK_LSB-1:0];
  assign term       = burst_done && cnt_en && (cur_cnt == CNT_W'(BURST_BYTES));

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_bit   <= 1'b0;
      chain_en  <= 1'b0;
      to_mem    <= 1'b0;
      dma_en    <= 1'b0;
      cnt_en    <= 1'b0;
      int_en    <= 1'b0;
      bsz       <= 2'b00;
      tc_q      <= 1'b0;
      err_q     <= 1'b0;
      cur_valid <= 1'b0;
      armed     <= 1'b0;
      cur_addr  <= '0;
      nxt_addr  <= '0;
      cur_cnt   <= '0;
      nxt_cnt   <= '0;
    end else begin
      if (csr_wr) begin
        rst_bit  <= reg_wdata[CSR_RST];
        chain_en <= reg_wdata[CSR_CHAIN];
        to_mem   <= reg_wdata[CSR_TOMEM];
        dma_en   <= reg_wdata[CSR_EN];
        cnt_en   <= reg_wdata[CSR_CNTEN];
        int_en   <= reg_wdata[CSR_IEN];
        bsz      <= reg_wdata[CSR_BSZ+1:CSR_BSZ];
        if (reg_wdata[CSR_TC]) tc_q <= 1'b0;
      end
      // advance after each completed burst
      if (burst_done) begin
        cur_addr <= cur_addr + ADDR_W'(BURST_BYTES);
        if (cnt_en) cur_cnt <= cur_cnt - CNT_W'(BURST_BYTES);
      end
      // terminal count: reload from the queue or stop
      if (term) begin
        tc_q <= 1'b1;
        if (chain_en && armed) begin
          cur_addr <= nxt_addr;
          cur_cnt  <= nxt_cnt;
          armed    <= 1'b0;
        end else begin
          cur_valid <= 1'b0;
        end
      end
      if (cnt_wr) nxt_cnt <= {reg_wdata[CNT_W-1:BLK_LSB], {BLK_LSB{1'b0}}};
      if (adr_wr) begin
        if (misaligned) begin
          err_q <= 1'b1;
        end else begin
          nxt_addr <= reg_wdata[ADDR_W-1:0];
          if (!cur_valid) begin
            cur_addr  <= reg_wdata[ADDR_W-1:0];
            cur_cnt   <= nxt_cnt;
            cur_valid <= (nxt_cnt != '0);
          end else begin
            armed <= (nxt_cnt != '0);
          end
        end
      end
      if (burst_err) err_q <= 1'b1;
      // soft reset wins over everything above
      if (csr_wr && reg_wdata[CSR_RST]) begin
        tc_q      <= 1'b0;
        err_q     <= 1'b0;
        cur_valid <= 1'b0;
        armed     <= 1'b0;
      end
    end
  end

  always_comb begin
    csr_view                      = '0;
    csr_view[CSR_RST]             = rst_bit;
    csr_view[CSR_TC]              = tc_q;
    csr_view[CSR_CPEND]           = cyc_pend;
    csr_view[CSR_DRAIN]           = draining;
    csr_view[CSR_CHAIN]           = chain_en;
    csr_view[CSR_TOMEM]           = to_mem;
    csr_view[CSR_EN]              = dma_en;
    csr_view[CSR_CNTEN]           = cnt_en;
    csr_view[CSR_IEN]             = int_en;
    csr_view[CSR_IPEND]           = tc_q && int_en;
    csr_view[CSR_ERR]             = err_q;
    csr_view[CSR_BSZ+1:CSR_BSZ]   = bsz;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= (tc_q && int_en) || err_q;
      if (reg_rd) begin
        case (reg_addr)
          OFF_CSR:  reg_rdata <= csr_view;
          OFF_ADDR: reg_rdata <= 32'(dma_en ? nxt_addr : cur_addr);
          OFF_CNT:  reg_rdata <= 32'(dma_en ? nxt_cnt : cur_cnt);
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end

  assign go         = dma_en && !rst_bit && !err_q && cur_valid;
  assign to_mem_o   = to_mem;
  assign abort_o    = rst_bit;
  assign err_o      = err_q;
  assign cur_addr_o = cur_addr;

  // R6: a one in the TC position clears the flag unless a new terminal count lands
  p_tc_w1c_r6: assert property (@(posedge clk) disable iff (rst)
    csr_wr && reg_wdata[CSR_TC] && !term |=> !tc_q);

  // R3: a queued buffer is taken over at terminal count
  p_chain_r3: assert property (@(posedge clk) disable iff (rst)
    term && chain_en && armed && !adr_wr && !(csr_wr && reg_wdata[CSR_RST])
    |=> cur_valid && !armed);
endmodule

// File: rtl/chain_dma_engine.sv
`timescale 1ns/1ps
module chain_dma_engine
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BURST_WORDS = 16,
  parameter int LEN_W       = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              to_mem,
  input  logic              abort,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_write,
  output logic [LEN_W-1:0]  mem_req_len,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rready,
  output logic              mem_wvalid,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_wready,
  input  logic              mem_err,
  output logic              per_tx_valid,
  input  logic              per_tx_ready,
  output logic [DATA_W-1:0] per_tx_data,
  input  logic              per_rx_valid,
  output logic              per_rx_ready,
  input  logic [DATA_W-1:0] per_rx_data,
  output logic              burst_done,
  output logic              burst_err,
  output logic              cyc_pend,
  output logic              draining
);
  localparam int BLK_LSB = $clog2(BURST_WORDS * DATA_W / 8);

  eng_state_t        st;
  logic [LEN_W-1:0]  beat_cnt;
  logic              dir_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_phase, wr_phase, in_drain, beat, last;

  assign rd_phase = (st == ENG_DATA) && !dir_q;
  assign wr_phase = (st == ENG_DATA) && dir_q;
  assign in_drain = (st == ENG_DRAIN);

  assign mem_rready   = (rd_phase && per_tx_ready) || (in_drain && !dir_q);
  assign per_tx_valid = rd_phase && mem_rvalid;
  assign per_tx_data  = mem_rdata;
  assign mem_wvalid   = (wr_phase && per_rx_valid) || (in_drain && dir_q);
  assign mem_wdata    = in_drain ? '0 : per_rx_data;
  assign per_rx_ready = wr_phase && mem_wready;

  assign beat = dir_q ? (mem_wvalid && mem_wready) : (mem_rvalid && mem_rready);
  assign last = beat && (beat_cnt == LEN_W'(BURST_WORDS - 1));

  assign burst_done = (st == ENG_DATA) && last && !mem_err && !abort;
  assign burst_err  = (st == ENG_DATA) && mem_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ENG_IDLE;
      beat_cnt <= '0;
      dir_q    <= 1'b0;
      addr_q   <= '0;
    end else begin
      case (st)
        ENG_IDLE: if (go && !abort) begin
          addr_q <= start_addr;
          dir_q  <= to_mem;
          st     <= ENG_REQ;
        end
        ENG_REQ: if (mem_req_ready) begin
          beat_cnt <= '0;
          st       <= abort ? ENG_DRAIN : ENG_DATA;
        end
        ENG_DATA: begin
          if (mem_err) begin
            st <= ENG_IDLE;
          end else begin
            if (beat) beat_cnt <= beat_cnt + 1'b1;
            if (last)       st <= ENG_IDLE;
            else if (abort) st <= ENG_DRAIN;
          end
        end
        default: begin
          if (mem_err || last) st <= ENG_IDLE;
          else if (beat)       beat_cnt <= beat_cnt + 1'b1;
        end
      endcase
    end
  end

  assign mem_req_valid = (st == ENG_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_req_write = dir_q;
  assign mem_req_len   = LEN_W'(BURST_WORDS);
  assign cyc_pend      = (st == ENG_REQ);
  assign draining      = in_drain;

  // R9: an offered request is held with a fixed address until accepted
  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R4: burst addresses sit on a burst boundary
  p_req_aligned_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[BLK_LSB-1:0] == '0));

  // R11: never read and write beats at once
  p_one_dir_r11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rready && mem_wvalid));
endmodule

// File: rtl/chain_dma_chan.sv
`timescale 1ns/1ps
module chain_dma_chan #(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 24,
  parameter int DATA_W      = 32,
  parameter int BURST_WORDS = 16,
  parameter int LEN_W       = $clog2(BURST_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_write,
  output logic [LEN_W-1:0]  mem_req_len,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rready,
  output logic              mem_wvalid,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_wready,
  input  logic              mem_err,
  output logic              per_tx_valid,
  input  logic              per_tx_ready,
  output logic [DATA_W-1:0] per_tx_data,
  input  logic              per_rx_valid,
  output logic              per_rx_ready,
  input  logic [DATA_W-1:0] per_rx_data
);
  localparam int BURST_BYTES = BURST_WORDS * DATA_W / 8;

  logic              go, to_mem, abort, err_pend;
  logic              burst_done, burst_err, cyc_pend, draining;
  logic [ADDR_W-1:0] cur_addr;

  chain_dma_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_BYTES(BURST_BYTES)
  ) regs_i (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .burst_done(burst_done), .burst_err(burst_err),
    .cyc_pend(cyc_pend), .draining(draining),
    .go(go), .to_mem_o(to_mem), .abort_o(abort), .err_o(err_pend),
    .cur_addr_o(cur_addr)
  );

  chain_dma_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_WORDS(BURST_WORDS), .LEN_W(LEN_W)
  ) eng_i (
    .clk(clk), .rst(rst),
    .go(go), .to_mem(to_mem), .abort(abort), .start_addr(cur_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_write(mem_req_write),
    .mem_req_len(mem_req_len),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rready(mem_rready),
    .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata), .mem_wready(mem_wready),
    .mem_err(mem_err),
    .per_tx_valid(per_tx_valid), .per_tx_ready(per_tx_ready), .per_tx_data(per_tx_data),
    .per_rx_valid(per_rx_valid), .per_rx_ready(per_rx_ready), .per_rx_data(per_rx_data),
    .burst_done(burst_done), .burst_err(burst_err),
    .cyc_pend(cyc_pend), .draining(draining)
  );

  // R10: a new request only follows a cycle with no error and no soft reset
  p_no_issue_blocked_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_valid) |-> $past(!err_pend && !abort));
endmodule

// File: tb/chain_dma_chan_tb_top.sv
`timescale 1ns/1ps
module chain_dma_chan_tb_top;
  localparam int CLK_NS = 8;
  localparam logic [31:0] B_RST = 32'h1,  B_TC = 32'h2,  B_CP = 32'h4,  B_DR = 32'h8;
  localparam logic [31:0] B_CH = 32'h10, B_TM = 32'h20, B_EN = 32'h40, B_CE = 32'h80;
  localparam logic [31:0] B_IE = 32'h100, B_IP = 32'h200, B_ER = 32'h400;

  // rows: addrA, cntA, addrB, cntB, expected bursts
  localparam logic [103:0] VEC [4] = '{
    {32'h0000_1000, 16'h0040, 32'h0000_2000, 16'h0080, 8'd3},
    {32'h0000_4000, 16'h00C0, 32'h0000_8000, 16'h0040, 8'd4},
    {32'h0001_0040, 16'h0080, 32'h0002_0000, 16'h0090, 8'd4},
    {32'h0000_FFC0, 16'h0040, 32'h0000_0000, 16'h0100, 8'd5}
  };

  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, mem_req_valid, mem_req_ready = 1, mem_req_write;
  logic [31:0] mem_req_addr;
  logic [4:0] mem_req_len;
  logic mem_rvalid = 0, mem_rready, mem_wvalid, mem_wready = 0, mem_err = 0;
  logic [31:0] mem_rdata = 0, mem_wdata;
  logic per_tx_valid, per_tx_ready = 1, per_rx_valid = 1, per_rx_ready;
  logic [31:0] per_tx_data, per_rx_data = 0;

  always #(CLK_NS/2) clk = ~clk;

  chain_dma_chan dut_i (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  // memory / peripheral model state
  int nb, nw, ntx, beats_left, ridx, rx_idx, lenbad, err_on;
  bit stall_req, hold_data, pending_err, mdir;
  logic [31:0] blog [64];
  bit          bwr  [64];
  logic [31:0] wlog [64];
  logic [31:0] rd_base, tx_first;
  logic s_rq = 0, s_wr = 0, s_rvf = 0, s_wf = 0, s_txf = 0, s_rxf = 0;
  logic [31:0] s_addr = 0, s_wdata = 0, s_txd = 0;
  logic [4:0] s_len = 0;

  always @(negedge clk) begin
    if (rst) begin
      nb = 0; nw = 0; ntx = 0; beats_left = 0; ridx = 0; rx_idx = 0;
      lenbad = 0; pending_err = 0; mdir = 0; rd_base = 0; tx_first = 0;
    end else begin
      if (s_rq) begin
        if (nb < 64) begin blog[nb] = s_addr; bwr[nb] = s_wr; end
        if (s_len != 5'd16) lenbad++;
        nb++;
        beats_left = 16; mdir = s_wr; rd_base = s_addr; ridx = 0;
        if (err_on == nb) pending_err = 1;
      end
      if (s_rvf) begin beats_left--; ridx++; end
      if (s_wf) begin
        beats_left--;
        if (nw < 64) wlog[nw] = s_wdata;
        nw++;
      end
      if (s_txf) begin
        if (ntx == 0) tx_first = s_txd;
        ntx++;
      end
      if (s_rxf) rx_idx++;
    end
    mem_req_ready = !stall_req;
    mem_err = 0;
    if (pending_err) begin mem_err = 1; pending_err = 0; beats_left = 0; end
    mem_rvalid  = (beats_left > 0) && !mdir && !hold_data;
    mem_rdata   = rd_base + 32'(ridx * 4);
    mem_wready  = (beats_left > 0) && mdir && !hold_data;
    per_rx_data = 32'hA000_0000 + 32'(rx_idx);
    #1;
    s_rq  = mem_req_valid && mem_req_ready;
    s_addr = mem_req_addr; s_wr = mem_req_write; s_len = mem_req_len;
    s_rvf = mem_rvalid && mem_rready;
    s_wf  = mem_wvalid && mem_wready; s_wdata = mem_wdata;
    s_txf = per_tx_valid && per_tx_ready; s_txd = per_tx_data;
    s_rxf = per_rx_valid && per_rx_ready;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic hard_reset();
    @(negedge clk); rst = 1; err_on = 0; stall_req = 0; hold_data = 0;
    cyc(3); rst = 0; cyc(1);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int nh;
    err_on = 0; stall_req = 0; hold_data = 0;

    // R1: reset state
    hard_reset();
    rd(4'h0, d);
    chk("R1 csr", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 req", {31'b0, mem_req_valid}, 32'h0);

    // R3 R4 R5 R11: chaining table
    for (int i = 0; i < 4; i++) begin
      logic [31:0] a0, a1, expa;
      logic [15:0] c0, c1;
      int ne, na, bad;
      {a0, c0, a1, c1} = VEC[i][103:8];
      ne = int'(VEC[i][7:0]);
      na = int'(c0) / 64;
      hard_reset();
      wr(4'h8, {16'h0, c0}); wr(4'h4, a0);
      wr(4'h8, {16'h0, c1}); wr(4'h4, a1);
      wr(4'h0, B_EN | B_CH | B_CE | B_IE);
      cyc(ne * 25 + 60);
      chk("R3 burst count", nb, ne);
      bad = 0;
      for (int k = 0; k < ne; k++) begin
        expa = (k < na) ? a0 + 32'(64 * k) : a1 + 32'(64 * (k - na));
        if (blog[k] !== expa) bad++;
      end
      chk("R4 burst addresses", bad, 0);
      chk("R4 burst length", lenbad, 0);
      rd(4'h0, d);
      chk("R5 tc and R7 ipend", d & (B_TC | B_IP), B_TC | B_IP);
      chk("R11 tx words", ntx, ne * 16);
      chk("R11 tx first word", tx_first, a0);
    end

    // R2: idle load, readback, queue held
    hard_reset();
    wr(4'h8, 32'h100); wr(4'h4, 32'h3000);
    rd(4'h4, d); chk("R2 cur addr", d, 32'h3000);
    rd(4'h8, d); chk("R2 cur cnt", d, 32'h100);
    wr(4'h8, 32'h40); wr(4'h4, 32'h5000);
    rd(4'h4, d); chk("R3 queued keeps current", d, 32'h3000);
    wr(4'h0, B_EN | B_CH | B_CE);
    rd(4'h4, d); chk("R2 next readback", d, 32'h5000);
    cyc(5 * 25 + 60);
    chk("R3 chained count", nb, 5);
    chk("R3 chained addr", blog[4], 32'h5000);

    // R8: halt mid buffer
    hard_reset();
    wr(4'h8, 32'h200); wr(4'h4, 32'h6000);
    wr(4'h0, B_EN | B_CE);
    cyc(45);
    wr(4'h0, B_CE);
    cyc(40);
    nh = nb;
    rd(4'h4, d); chk("R8 held addr", d, 32'h6000 + 32'(nh * 64));
    rd(4'h8, d); chk("R8 held cnt", d, 32'h200 - 32'(nh * 64));
    cyc(60);
    chk("R8 no new burst", nb, nh);
    wr(4'h0, B_EN | B_CE);
    cyc(8 * 25 + 60);
    chk("R8 resumed total", nb, 8);
    chk("R8 last addr", blog[7], 32'h61C0);

    // R5 R6 R7: stop without queue, TC write-one-to-clear
    cyc(60);
    chk("R5 stopped", nb, 8);
    rd(4'h0, d); chk("R5 tc held", d & (B_TC | B_IP), B_TC);
    chk("R7 irq low", {31'b0, irq}, 32'h0);
    wr(4'h0, B_CE | B_IE);
    rd(4'h0, d); chk("R6 tc kept by zero", d & (B_TC | B_IP | B_CE), B_TC | B_IP | B_CE);
    chk("R7 irq high", {31'b0, irq}, 32'h1);
    wr(4'h0, B_TC | B_CE);
    rd(4'h0, d); chk("R6 tc cleared", d, B_CE);
    cyc(2);
    chk("R7 irq after clear", {31'b0, irq}, 32'h0);

    // R11: capture direction
    hard_reset();
    wr(4'h8, 32'h40); wr(4'h4, 32'h7000);
    wr(4'h0, B_EN | B_CE | B_TM);
    cyc(60);
    chk("R11 write bursts", nb, 1);
    chk("R11 write flag", {31'b0, bwr[0]}, 32'h1);
    chk("R11 write beats", nw, 16);
    chk("R11 first word", wlog[0], 32'hA000_0000);
    chk("R11 last word", wlog[15], 32'hA000_000F);

    // R10: error response
    hard_reset();
    err_on = 2;
    wr(4'h8, 32'h100); wr(4'h4, 32'h9000);
    wr(4'h0, B_EN | B_CE);
    cyc(150);
    chk("R10 abandoned", nb, 2);
    rd(4'h0, d); chk("R10 err bit", d & B_ER, B_ER);
    chk("R10 irq", {31'b0, irq}, 32'h1);
    wr(4'h0, B_RST | B_TC);
    rd(4'h0, d); chk("R9 reset clears err", d & (B_ER | B_TC), 32'h0);

    // R10: misaligned address
    hard_reset();
    wr(4'h8, 32'h40); wr(4'h4, 32'h9010);
    wr(4'h0, B_EN | B_CE);
    cyc(50);
    chk("R10 misaligned no burst", nb, 0);
    rd(4'h0, d); chk("R10 misaligned err", d & B_ER, B_ER);

    // R9: reset / drain handshake
    hard_reset();
    stall_req = 1;
    wr(4'h8, 32'h80); wr(4'h4, 32'hA000);
    wr(4'h0, B_EN | B_CE);
    cyc(5);
    wr(4'h0, B_RST | B_TC | B_EN | B_CE);
    rd(4'h0, d); chk("R9 pending visible", d & (B_CP | B_DR), B_CP);
    hold_data = 1; stall_req = 0;
    cyc(5);
    rd(4'h0, d); chk("R9 drain visible", d & (B_CP | B_DR), B_DR);
    hold_data = 0;
    cyc(40);
    rd(4'h0, d); chk("R9 quiet", d & (B_CP | B_DR | B_RST), B_RST);
    chk("R9 drained to nowhere", ntx, 0);
    wr(4'h0, B_EN | B_CE);
    cyc(60);
    chk("R9 buffers cleared", nb, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule